// File: doc/BRIEF.md
# Serial Flash Row-Erase Programmer Sequencer

This block is the host side of a two-wire in-circuit programming link. It drives a programming clock and a data line toward a target microcontroller and erases the target's program flash one 1024-byte row at a time. Each row is wiped by sending a fixed script of transactions. Every transaction is a 4-bit command followed by a 16-bit payload that the target runs as a core instruction. The script arms writes, points the target's table pointer at the row, selects the erase operation and fires it. A final no-op transaction then keeps its fourth clock high while the target times the erase itself.

Software or a bring-up controller loads the number of rows and the erase hold time, then pulses `start`. The sequencer keeps `busy` high while the rows are processed from address zero upward. A one-cycle `done` pulse marks the end. The clock half-periods are build-time parameters. The erase hold is sampled when a start is accepted.

Top module: `flash_row_wiper`

## Requirements
- R1: Each transaction is 20 clock pulses on `prog_clk`. The first 4 carry the command and the next 16 carry the payload, each least-significant bit first, and the target samples `prog_dat` on the falling edge. The command is always 4'b0000.
- R2: For row 0 the payloads are sent in this order: 0x84A6, 0x6AF8, 0x6AF7, 0x6AF6, 0x88A6, 0x82A6, then the no-op 0x0000.
- R3: For row n>0, with A = n*1024 as a 24-bit address, the payloads are 0x84A6, {0x0E,A[23:16]}, 0x6EF8, {0x0E,A[15:8]}, 0x6EF7, {0x0E,A[7:0]}, 0x6EF6, 0x88A6, 0x82A6, 0x0000. Rows are sent in ascending order from row 0 to row `row_count`-1.
- R4: In each no-op transaction the 4th clock pulse stays high for exactly `erase_hold` cycles, and a value of 0 counts as 1. Every other high phase lasts HALF_HI cycles. Every low phase inside a transaction lasts HALF_LO cycles.
- R5: `prog_dat` changes only in a cycle where `prog_clk` is high.
- R6: `busy` is high from the cycle after an accepted start until the last no-op transaction ends. `done` is high for exactly one cycle, which is the first cycle in which `busy` is low again.
- R7: A `start` pulse while `busy` is high has no effect on the transaction stream or on the number of rows.
- R8: A start with `row_count` = 0 produces a `done` pulse in the next cycle. `busy` stays low and `prog_clk` never rises.
- R9: `prog_dat_oe` is high exactly when `busy` is high.
- R10: After reset, `prog_clk`, `prog_dat`, `prog_dat_oe`, `busy` and `done` are all low.
- R11: `row_count` and `erase_hold` are captured at the accepted start, and later changes to them have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an erase run |
| row_count | input | ROW_W | Number of rows to erase, starting at row 0 |
| erase_hold | input | HOLD_W | Cycles the stretched clock pulse stays high |
| prog_clk | output | 1 | Programming clock to the target |
| prog_dat | output | 1 | Serial data to the target |
| prog_dat_oe | output | 1 | Output enable for the data pad |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench decodes the wire traffic on every falling clock edge and rebuilds each transaction. It compares them against the scripts expected per row. Random runs with a few rows and random hold values test the move from the first-row script to the later-row script, and test that the no-op pulse is stretched by the loaded amount rather than a fixed one. A 66-row run reaches a nonzero upper address byte, which shows whether the address bytes are placed correctly. Directed runs cover a zero-row start, a hold of one cycle, and a second start with changed inputs during a run, which shows whether the inputs are captured once or followed live.

// File: rtl/row_wipe_pkg.sv
package row_wipe_pkg;

    localparam int CMD_BITS   = 4;
    localparam int WORD_BITS  = 16;
    localparam int FRAME_BITS = CMD_BITS + WORD_BITS;
    localparam int STEP_W     = 4;
    localparam int ADDR_BITS  = 24;

    localparam logic [CMD_BITS-1:0] CMD_CORE = 4'b0000;

    localparam logic [WORD_BITS-1:0] W_ARM_WRITE  = 16'h84A6;
    localparam logic [WORD_BITS-1:0] W_ZERO_UP    = 16'h6AF8;
    localparam logic [WORD_BITS-1:0] W_ZERO_MID   = 16'h6AF7;
    localparam logic [WORD_BITS-1:0] W_ZERO_LO    = 16'h6AF6;
    localparam logic [WORD_BITS-1:0] W_PUT_UP     = 16'h6EF8;
    localparam logic [WORD_BITS-1:0] W_PUT_MID    = 16'h6EF7;
    localparam logic [WORD_BITS-1:0] W_PUT_LO     = 16'h6EF6;
    localparam logic [WORD_BITS-1:0] W_PICK_ERASE = 16'h88A6;
    localparam logic [WORD_BITS-1:0] W_FIRE       = 16'h82A6;
    localparam logic [WORD_BITS-1:0] W_IDLE_OP    = 16'h0000;
    localparam logic [7:0]           OP_LITERAL   = 8'h0E;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_HIGH,
        SH_LOW
    } sh_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } sq_state_e;

endpackage

// File: rtl/rw_row_script.sv
module rw_row_script
    import row_wipe_pkg::*;
#(
    parameter int ROW_W     = 8,
    parameter int ROW_LOG2  = 10
) (
    input  logic [ROW_W-1:0]     row,
    input  logic [STEP_W-1:0]    step,
    output logic [WORD_BITS-1:0] word,
    output logic                 is_nop,
    output logic                 last
);

    localparam logic [STEP_W-1:0] FIRST_LAST = STEP_W'(6);
    localparam logic [STEP_W-1:0] LATER_LAST = STEP_W'(9);

    logic [ADDR_BITS-1:0] row_addr;
    logic                 first_row;

    always_comb begin
        row_addr  = ADDR_BITS'(row) << ROW_LOG2;
        first_row = (row == '0);
    end

    always_comb begin
        word = W_IDLE_OP;
        if (first_row) begin
            case (step)
                4'd0:    word = W_ARM_WRITE;
                4'd1:    word = W_ZERO_UP;
                4'd2:    word = W_ZERO_MID;
                4'd3:    word = W_ZERO_LO;
                4'd4:    word = W_PICK_ERASE;
                4'd5:    word = W_FIRE;
                default: word = W_IDLE_OP;
            endcase
            last = (step == FIRST_LAST);
        end else begin
            case (step)
                4'd0:    word = W_ARM_WRITE;
                4'd1:    word = {OP_LITERAL, row_addr[23:16]};
                4'd2:    word = W_PUT_UP;
                4'd3:    word = {OP_LITERAL, row_addr[15:8]};
                4'd4:    word = W_PUT_MID;
                4'd5:    word = {OP_LITERAL, row_addr[7:0]};
                4'd6:    word = W_PUT_LO;
                4'd7:    word = W_PICK_ERASE;
                4'd8:    word = W_FIRE;
                default: word = W_IDLE_OP;
            endcase
            last = (step == LATER_LAST);
        end
        is_nop = last;
    end

endmodule

// File: rtl/rw_frame_shifter.sv
module rw_frame_shifter
    import row_wipe_pkg::*;
#(
    parameter int HALF_HI     = 2,
    parameter int HALF_LO     = 2,
    parameter int HOLD_W      = 12,
    parameter int STRETCH_BIT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [CMD_BITS-1:0]  cmd,
    input  logic [WORD_BITS-1:0] payload,
    input  logic                 stretch,
    input  logic [HOLD_W-1:0]    hold,
    output logic                 frame_done,
    output logic                 line_clk,
    output logic                 line_dat
);

    localparam int HL_MAX = (HALF_HI > HALF_LO) ? HALF_HI : HALF_LO;
    localparam int HP_W   = $clog2(HL_MAX + 1);
    localparam int LEN_W  = (HOLD_W > HP_W) ? HOLD_W : HP_W;
    localparam int IDX_W  = $clog2(FRAME_BITS);
    localparam logic [LEN_W-1:0] HI_LEN  = LEN_W'(HALF_HI - 1);
    localparam logic [LEN_W-1:0] LO_LEN  = LEN_W'(HALF_LO - 1);
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] STR_IX  = IDX_W'(STRETCH_BIT);

    typedef struct packed {
        sh_state_e             state;
        logic [LEN_W-1:0]      cnt;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sreg;
        logic                  stretch;
        logic                  clk;
        logic                  dat;
    } sh_t;

    sh_t q, d;
    logic [LEN_W-1:0] hold_len;

    always_comb begin
        hold_len   = (hold == '0) ? '0 : LEN_W'(hold - 1'b1);
        d          = q;
        frame_done = 1'b0;
        case (q.state)
            SH_IDLE: begin
                if (go) begin
                    d.sreg    = {payload, cmd};
                    d.idx     = '0;
                    d.stretch = stretch;
                    d.state   = SH_HIGH;
                    d.cnt     = (stretch && STR_IX == '0) ? hold_len : HI_LEN;
                    d.clk     = 1'b1;
                    d.dat     = cmd[0];
                end
            end
            SH_HIGH: begin
                if (q.cnt == '0) begin
                    d.state = SH_LOW;
                    d.cnt   = LO_LEN;
                    d.clk   = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SH_LOW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.idx == LAST_IX) begin
                    d.state    = SH_IDLE;
                    frame_done = 1'b1;
                end else begin
                    d.sreg  = q.sreg >> 1;
                    d.idx   = q.idx + 1'b1;
                    d.state = SH_HIGH;
                    d.clk   = 1'b1;
                    d.dat   = q.sreg[1];
                    d.cnt   = (q.stretch && (q.idx + 1'b1) == STR_IX) ? hold_len : HI_LEN;
                end
            end
            default: d.state = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SH_IDLE, cnt: '0, idx: '0, sreg: '0,
                   stretch: 1'b0, clk: 1'b0, dat: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign line_clk = q.clk;
    assign line_dat = q.dat;

    p_dat_moves_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dat != $past(q.dat)) |-> q.clk);

    p_go_only_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (q.state == SH_IDLE));

    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= LAST_IX);

    p_idle_clock_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SH_IDLE) |-> !q.clk);

endmodule

// File: rtl/flash_row_wiper.sv
module flash_row_wiper
    import row_wipe_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int HOLD_W   = 12,
    parameter int HALF_HI  = 2,
    parameter int HALF_LO  = 2,
    parameter int ROW_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_count,
    input  logic [HOLD_W-1:0] erase_hold,
    output logic              prog_clk,
    output logic              prog_dat,
    output logic              prog_dat_oe,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        sq_state_e         state;
        logic [ROW_W-1:0]  row;
        logic [ROW_W-1:0]  rows;
        logic [STEP_W-1:0] step;
        logic [HOLD_W-1:0] hold;
        logic              done;
    } sq_t;

    sq_t q, d;

    logic [WORD_BITS-1:0] cur_word;
    logic                 cur_nop;
    logic                 cur_last;
    logic                 frame_done;
    logic                 issue;

    rw_row_script #(
        .ROW_W    (ROW_W),
        .ROW_LOG2 (ROW_LOG2)
    ) u_script (
        .row    (q.row),
        .step   (q.step),
        .word   (cur_word),
        .is_nop (cur_nop),
        .last   (cur_last)
    );

    rw_frame_shifter #(
        .HALF_HI     (HALF_HI),
        .HALF_LO     (HALF_LO),
        .HOLD_W      (HOLD_W),
        .STRETCH_BIT (3)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (issue),
        .cmd        (CMD_CORE),
        .payload    (cur_word),
        .stretch    (cur_nop),
        .hold       (q.hold),
        .frame_done (frame_done),
        .line_clk   (prog_clk),
        .line_dat   (prog_dat)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        issue  = (q.state == SQ_ISSUE);
        case (q.state)
            SQ_IDLE: begin
                if (start) begin
                    if (row_count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.rows  = row_count;
                        d.hold  = erase_hold;
                        d.row   = '0;
                        d.step  = '0;
                        d.state = SQ_ISSUE;
                    end
                end
            end
            SQ_ISSUE: d.state = SQ_WAIT;
            SQ_WAIT: begin
                if (frame_done) begin
                    if (!cur_last) begin
                        d.step  = q.step + 1'b1;
                        d.state = SQ_ISSUE;
                    end else if (q.row == q.rows - 1'b1) begin
                        d.state = SQ_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.row   = q.row + 1'b1;
                        d.step  = '0;
                        d.state = SQ_ISSUE;
                    end
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SQ_IDLE, row: '0, rows: '0, step: '0, hold: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.state != SQ_IDLE);
    assign done        = q.done;
    assign prog_dat_oe = busy;

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fall_gives_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_row_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.row < q.rows));

    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.rows) && $stable(q.hold)));

    p_zero_rows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && row_count == '0) |=> (done && !busy));

    p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !prog_clk);

endmodule

// File: tb/flash_row_wiper_tb.sv
module flash_row_wiper_tb;

    localparam int ROW_W  = 8;
    localparam int HOLD_W = 12;
    localparam int HI     = 2;
    localparam int LO     = 3;
    localparam int MAXF   = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ROW_W-1:0]  row_count = '0;
    logic [HOLD_W-1:0] erase_hold = '0;
    logic              prog_clk, prog_dat, prog_dat_oe, busy, done;

    always #10 clk = ~clk;

    flash_row_wiper #(
        .ROW_W (ROW_W), .HOLD_W (HOLD_W), .HALF_HI (HI), .HALF_LO (LO), .ROW_LOG2 (10)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .row_count (row_count),
        .erase_hold (erase_hold), .prog_clk (prog_clk), .prog_dat (prog_dat),
        .prog_dat_oe (prog_dat_oe), .busy (busy), .done (done)
    );

    int checks = 0;
    int fails  = 0;

    // monitor state
    logic [19:0] fr [MAXF];
    logic [19:0] cur_bits;
    int          hw [20];
    int          nframes, bitpos, hi_cnt, lo_cnt, rises, done_cnt;
    int          bad_w, bad_lo, bad_dat, bad_oe;
    int          exp_hold;
    logic        prev_clk, prev_dat;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [15:0] exp_word(int row, int step);
        logic [23:0] a;
        a = 24'(row) << 10;
        if (row == 0) begin
            case (step)
                0: return 16'h84A6;
                1: return 16'h6AF8;
                2: return 16'h6AF7;
                3: return 16'h6AF6;
                4: return 16'h88A6;
                5: return 16'h82A6;
                default: return 16'h0000;
            endcase
        end
        case (step)
            0: return 16'h84A6;
            1: return {8'h0E, a[23:16]};
            2: return 16'h6EF8;
            3: return {8'h0E, a[15:8]};
            4: return 16'h6EF7;
            5: return {8'h0E, a[7:0]};
            6: return 16'h6EF6;
            7: return 16'h88A6;
            8: return 16'h82A6;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int steps_of(int row);
        return (row == 0) ? 7 : 10;
    endfunction

    task automatic clear_mon();
        nframes = 0; bitpos = 0; hi_cnt = 0; lo_cnt = 0; rises = 0; done_cnt = 0;
        bad_w = 0; bad_lo = 0; bad_dat = 0; bad_oe = 0; cur_bits = '0;
    endtask

    initial begin
        clear_mon();
        prev_clk = 1'b0;
        prev_dat = 1'b0;
        exp_hold = 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_dat != prev_dat && !prog_clk) bad_dat++;
            if (prog_dat_oe != busy) bad_oe++;
            if (done) done_cnt++;
            if (prog_clk) hi_cnt++;
            else lo_cnt++;
            if (prog_clk && !prev_clk) begin
                rises++;
                if (bitpos != 0 && lo_cnt != LO) bad_lo++;
                lo_cnt = 0;
            end
            if (!prog_clk && prev_clk) begin
                cur_bits[bitpos] = prog_dat;
                hw[bitpos] = hi_cnt;
                hi_cnt = 0;
                lo_cnt = 1;
                bitpos++;
                if (bitpos == 20) begin
                    for (int b = 0; b < 20; b++) begin
                        int e;
                        e = (b == 3 && cur_bits[19:4] == 16'h0000) ? exp_hold : HI;
                        if (hw[b] != e) bad_w++;
                    end
                    if (nframes < MAXF) fr[nframes] = cur_bits;
                    nframes++;
                    bitpos = 0;
                end
            end
            prev_clk = prog_clk;
            prev_dat = prog_dat;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
            report();
        end
    end

    task automatic run_case(input int rows, input int hold, input bit poke, input string tag);
        int want, idx, bad_fr, first_bad, guard;
        logic [19:0] got;
        @(posedge clk);
        clear_mon();
        exp_hold = (hold == 0) ? 1 : hold;
        @(negedge clk);
        row_count  = ROW_W'(rows);
        erase_hold = HOLD_W'(hold);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6", {tag, " busy after start"}, busy, 1);
        if (poke) begin
            repeat (150) @(negedge clk);
            // R7 R11: second start with new values must be ignored
            row_count  = ROW_W'(rows + 3);
            erase_hold = HOLD_W'(hold + 5);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 150000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1 && busy == 1'b0, "R6", {tag, " done with busy low"}, {done, busy}, 2'b10);
        repeat (6) @(negedge clk);
        @(posedge clk);
        want = 7 + 10 * (rows - 1);
        chk(nframes == want, "R3", {tag, " frame count"}, nframes, want);
        chk(done_cnt == 1, "R6", {tag, " done cycles"}, done_cnt, 1);
        bad_fr = 0; first_bad = -1; idx = 0;
        for (int r = 0; r < rows; r++) begin
            for (int s = 0; s < steps_of(r); s++) begin
                got = (idx < MAXF) ? fr[idx] : 20'hFFFFF;
                if (idx >= nframes || got != {exp_word(r, s), 4'b0000}) begin
                    if (first_bad < 0) first_bad = idx;
                    bad_fr++;
                end
                idx++;
            end
        end
        if (first_bad >= 0 && first_bad < MAXF) begin
            chk(1'b0, "R2/R3", {tag, " first bad frame"}, fr[first_bad], first_bad);
        end
        chk(bad_fr == 0, "R1", {tag, " mismatched frames"}, bad_fr, 0);
        chk(bad_w == 0, "R4", {tag, " high-phase widths"}, bad_w, 0);
        chk(bad_lo == 0, "R4", {tag, " low-phase widths"}, bad_lo, 0);
        chk(bad_dat == 0, "R5", {tag, " data moved while clock low"}, bad_dat, 0);
        chk(bad_oe == 0, "R9", {tag, " oe vs busy"}, bad_oe, 0);
    endtask

    initial begin
        void'($urandom(32'd90125));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({prog_clk, prog_dat, prog_dat_oe, busy, done} == 5'b0, "R10", "outputs in reset",
            {prog_clk, prog_dat, prog_dat_oe, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({prog_clk, prog_dat, prog_dat_oe, busy, done} == 5'b0, "R10", "outputs after reset",
            {prog_clk, prog_dat, prog_dat_oe, busy, done}, 0);

        // R8 zero rows
        @(posedge clk);
        clear_mon();
        @(negedge clk);
        row_count = '0; erase_hold = 12'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R8", "zero rows done/busy", {done, busy}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0, "R8", "zero rows done width", done, 0);
        repeat (20) @(negedge clk);
        chk(rises == 0, "R8", "zero rows clock activity", rises, 0);

        // directed: single row, minimal hold
        run_case(1, 1, 1'b0, "one-row");
        // R4 hold of zero counts as one
        run_case(2, 0, 1'b0, "hold-zero");
        // R7 R11 start while busy
        run_case(2, 9, 1'b1, "restart");
        // random runs
        for (int k = 0; k < 5; k++) begin
            int rr, hh;
            rr = 1 + int'($urandom % 4);
            hh = 1 + int'($urandom % 40);
            run_case(rr, hh, 1'b0, $sformatf("rand%0d", k));
        end
        // R3 upper address byte nonzero
        run_case(66, 1, 1'b0, "long");
        report();
    end

endmodule